// File: doc/BRIEF.md
# Toggle-Bit Status Poller

This block runs on the host side of a parallel flash device. It works out when a program or erase operation inside the device has finished. After a one-cycle `start` pulse it issues status reads over a simple request/acknowledge bus. It compares the toggle bit of consecutive reads and watches the device's time-limit flag. It then reports success, or reports failure after writing a reset command to the device. When the toggle bit stops changing between two reads, the operation is complete, and the next read cycle returns array data.

The time-limit flag is not trusted on its own. The toggle bit may have stopped at the same moment the flag rose, so after the flag is seen the poller takes two more reads. It only declares a failure if toggling is still present in those reads. A `pause` input lets the host leave the loop at any time. On resume, polling always starts again with a fresh pair of reads. An iteration limit guards against a device that never settles.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: A bus transaction holds `bus_req` high, with stable `bus_we`, `bus_addr` and `bus_wdata`, until the cycle in which `bus_ack` is high. Read data is taken only in that cycle. Reads have `bus_we` low.
- R2: Suppose two consecutive status reads return the same value on bit TOG_BIT (default 6). The poller then ends with `done` and no `error`, and it issues no write.
- R3: Suppose the toggle bit differs between the two reads and bit TMO_BIT (default 5) of the second read is 0. The poller then begins a new pair of reads, and does not compare against the earlier pair.
- R4: Suppose the toggle bit differs and bit TMO_BIT of the second read is 1. The poller then takes two more reads. If their toggle bits match, it ends with `done` and no `error`.
- R5: Suppose those two extra reads still differ on the toggle bit. The poller then writes `rst_cmd` to `poll_addr` (`bus_we` high), and after that write is acknowledged it pulses `done` and `error` together.
- R6: After MAX_POLLS pairs that toggle with the time-limit bit low, the poller writes `rst_cmd` and reports `done` with `error`.
- R7: `done` and `error` are one-cycle pulses. `busy` rises the cycle after `start` and stays high until the cycle `done` is driven, when it is low.
- R8: While `pause` is high outside a write, no request is made and `busy` stays high. After `pause` falls, polling resumes with a fresh pair of reads.
- R9: When `bus_ack` and `pause` are high in the same cycle, the read completes first. The pause then takes effect on the next transaction.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins polling |
| pause | input | 1 | Level; suspends polling while high |
| poll_addr | input | AW | Address used for status reads and the reset write |
| rst_cmd | input | DW | Data value written to abort a failed operation |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | High for the reset-command write |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transaction completes in this cycle |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle failure pulse, coincident with `done` |

## Verification
A read completion and a pause request can land in the same clock. The read must win, so the captured toggle bit is kept and the pause only takes effect afterwards. The bench forces this by raising `pause` in the very cycle its bus model returns `bus_ack`. It then requires `bus_req` to be seen high for the following read before the request drops. A second pause test catches a poller that resumes mid-pair: it feeds data that produces a different read count unless the comparison restarts from a fresh pair.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int TOG_BIT   = 6,
  parameter int TMO_BIT   = 5,
  parameter int MAX_POLLS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pause,
  input  logic [AW-1:0] poll_addr,
  input  logic [DW-1:0] rst_cmd,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam int IW = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_RD2, S_CHK1, S_CHK2, S_RST, S_HOLD
  } st_t;

  st_t           st;
  logic          first_tog;
  logic [IW-1:0] iter;

  wire rd_st = (st == S_RD1) || (st == S_RD2) || (st == S_CHK1) || (st == S_CHK2);
  wire same  = bus_rdata[TOG_BIT] == first_tog;

  assign bus_req   = rd_st || (st == S_RST);
  assign bus_we    = (st == S_RST);
  assign bus_addr  = poll_addr;
  assign bus_wdata = rst_cmd;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      first_tog <= 1'b0;
      iter      <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_RD1;
          iter <= '0;
        end
        S_RD1, S_CHK1: begin
          if (bus_ack) begin
            first_tog <= bus_rdata[TOG_BIT];
            st        <= (st == S_RD1) ? S_RD2 : S_CHK2;
          end else if (pause) st <= S_HOLD;
        end
        S_RD2: begin
          if (bus_ack) begin
            if (same) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else if (bus_rdata[TMO_BIT]) st <= S_CHK1;
            else if (iter == IW'(MAX_POLLS - 1)) st <= S_RST;
            else begin
              iter <= iter + 1'b1;
              st   <= S_RD1;
            end
          end else if (pause) st <= S_HOLD;
        end
        S_CHK2: begin
          if (bus_ack) begin
            if (same) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else st <= S_RST;
          end else if (pause) st <= S_HOLD;
        end
        S_RST: if (bus_ack) begin
          done  <= 1'b1;
          error <= 1'b1;
          st    <= S_IDLE;
        end
        S_HOLD: if (!pause) st <= S_RD1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && (bus_we || !pause)) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));
  p_err_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> $past(bus_req && bus_we && bus_ack));
  p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
endmodule

// File: tb/toggle_poll_ctrl_tb.sv
module toggle_poll_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pause = 1'b0;
  logic [15:0] poll_addr = 16'h0555;
  logic [7:0]  rst_cmd = 8'hF0;
  logic bus_req, bus_we, busy, done, error;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = 8'h00;
  logic        bus_ack = 1'b0;

  int checks = 0, fails = 0;
  int rd_idx = 0, wr_cnt = 0, wait_cnt = 0, lat = 1;
  logic [7:0] wr_val = 8'h00;
  logic [7:0] wr_addr_lo = 8'h00;
  logic [7:0] seq [0:15];

  always #4 clk = ~clk;

  toggle_poll_ctrl #(.AW(16), .DW(8), .TOG_BIT(6), .TMO_BIT(5), .MAX_POLLS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pause(pause),
    .poll_addr(poll_addr), .rst_cmd(rst_cmd),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .busy(busy), .done(done), .error(error));

  always @(negedge clk) begin
    bus_ack <= 1'b0;
    if (!bus_req) wait_cnt = 0;
    else if (!bus_ack) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        bus_ack <= 1'b1;
        if (bus_we) begin
          wr_cnt = wr_cnt + 1;
          wr_val = bus_wdata;
          wr_addr_lo = bus_addr[7:0];
        end else begin
          bus_rdata <= seq[(rd_idx > 15) ? 15 : rd_idx];
          rd_idx = rd_idx + 1;
        end
      end else wait_cnt = wait_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic begin_test(input int l);
    step();
    lat = l; rd_idx = 0; wr_cnt = 0; wr_val = 8'h00;
  endtask

  task automatic pulse_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic wait_done(input string req, output logic got_err);
    bit seen = 0;
    got_err = 1'b0;
    for (int i = 0; i < 400; i++) begin
      step();
      if (done) begin seen = 1; got_err = error; break; end
    end
    chk(req, int'(seen), 1);
    chk("R7 busy low with done", int'(busy), 0);
    step();
    chk("R7 done one cycle", int'(done), 0);
    chk("R7 error one cycle", int'(error), 0);
  endtask

  task automatic t_reset();
    chk("R7 reset busy", int'(busy), 0);
    chk("R7 reset done", int'(done), 0);
    chk("R1 reset req", int'(bus_req), 0);
  endtask

  task automatic t_quick_done();
    logic e;
    begin_test(1);
    seq[0] = 8'h00; seq[1] = 8'h00;
    pulse_start();
    chk("R7 busy after start", int'(busy), 1);
    chk("R1 read has we low", int'(bus_we), 0);
    wait_done("R2 done seen", e);
    chk("R2 no error", int'(e), 0);
    chk("R2 two reads", rd_idx, 2);
    chk("R2 no write", wr_cnt, 0);
  endtask

  task automatic t_toggle_then_stop();
    logic e;
    begin_test(2);
    seq[0] = 8'h00; seq[1] = 8'h40; seq[2] = 8'h40; seq[3] = 8'h40;
    pulse_start();
    while (rd_idx < 1) step();
    pulse_start();
    wait_done("R3 done seen", e);
    chk("R3 no error", int'(e), 0);
    chk("R3 fresh pair reads", rd_idx, 4);
    chk("R10 restart ignored", wr_cnt, 0);
  endtask

  task automatic t_timeout_ok();
    logic e;
    begin_test(1);
    seq[0] = 8'h00; seq[1] = 8'h60; seq[2] = 8'h00; seq[3] = 8'h00;
    pulse_start();
    wait_done("R4 done seen", e);
    chk("R4 no error", int'(e), 0);
    chk("R4 reads", rd_idx, 4);
    chk("R4 no write", wr_cnt, 0);
  endtask

  task automatic t_timeout_fail();
    logic e;
    begin_test(1);
    seq[0] = 8'h00; seq[1] = 8'h60; seq[2] = 8'h00; seq[3] = 8'h40;
    pulse_start();
    wait_done("R5 done seen", e);
    chk("R5 error", int'(e), 1);
    chk("R5 reads", rd_idx, 4);
    chk("R5 one write", wr_cnt, 1);
    chk("R5 write data", int'(wr_val), 8'hF0);
    chk("R5 write addr", int'(wr_addr_lo), 8'h55);
  endtask

  task automatic t_limit();
    logic e;
    begin_test(0);
    for (int i = 0; i < 16; i++) seq[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
    pulse_start();
    wait_done("R6 done seen", e);
    chk("R6 error", int'(e), 1);
    chk("R6 reads", rd_idx, 8);
    chk("R6 one write", wr_cnt, 1);
  endtask

  task automatic t_pause_restart();
    logic e;
    begin_test(3);
    seq[0] = 8'h00; seq[1] = 8'h40; seq[2] = 8'h40; seq[3] = 8'h00; seq[4] = 8'h00;
    pulse_start();
    while (rd_idx < 1) step();
    step();
    pause = 1'b1;
    step(); step();
    chk("R8 req dropped", int'(bus_req), 0);
    chk("R8 busy held", int'(busy), 1);
    repeat (6) step();
    chk("R8 no reads paused", rd_idx, 1);
    pause = 1'b0;
    wait_done("R8 done seen", e);
    chk("R8 no error", int'(e), 0);
    chk("R8 fresh pair after resume", rd_idx, 3);
  endtask

  task automatic t_pause_with_ack();
    logic e;
    begin_test(3);
    seq[0] = 8'h00; seq[1] = 8'h40; seq[2] = 8'h40; seq[3] = 8'h00;
    pulse_start();
    while (rd_idx < 1) step();
    pause = 1'b1;
    step();
    chk("R9 read completed before pause", int'(bus_req), 1);
    step();
    chk("R9 pause then taken", int'(bus_req), 0);
    repeat (3) step();
    pause = 1'b0;
    wait_done("R9 done seen", e);
    chk("R9 no error", int'(e), 0);
    chk("R9 reads", rd_idx, 3);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) seq[i] = 8'h00;
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_quick_done();
    t_toggle_then_stop();
    t_timeout_ok();
    t_timeout_fail();
    t_limit();
    t_pause_restart();
    t_pause_with_ack();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule